// File: doc/BRIEF.md
# Triggered One-Shot Strobe Timer

This block is a single down-counting channel that emits one active-low strobe, exactly one clock wide, a programmed number of clocks after a trigger. It has two trigger sources, picked by a mode select. In software mode, accepting a count on the load port starts the count, and the gate input acts as a level inhibit. In hardware mode, a rising edge on the gate input starts the count, and a later rising edge restarts it. After the strobe the channel goes idle until the next trigger.

The gate input may be asynchronous. It passes through a two-stage synchronizer and a registered edge detector in the counting clock domain. The count arrives on a valid/ready port. `load_ready` is always high, so the port never applies back-pressure, and a count is taken on every clock edge where `load_valid` is high. The mode select is a quasi-static control pin. Changing it returns the channel to idle.

Top module: `strb_timer`

## Requirements
- R1: After reset, and on the clock edge after the mode select changes value, `strobe_n` is high and no count is running. No strobe occurs until a new trigger.
- R2: Each strobe holds `strobe_n` low for exactly one clock period, then it returns high.
- R3: Software mode (`mode_hw`=0), gate held high: a count N (1 or more) accepted at clock edge k drives `strobe_n` low from edge k+N until edge k+N+1.
- R4: Software mode: each clock edge at which the synchronized gate is low does not decrement the count, so the strobe moves later by that number of clocks. A gate low pulse of L clocks applied while counting delays the strobe by exactly L clocks.
- R5: Software mode: a count accepted while counting restarts the count from the new value, and the old count produces no strobe.
- R6: Hardware mode (`mode_hw`=1): a gate rising edge first sampled high at clock edge t loads the stored count N at edge t+2. `strobe_n` is then low from edge t+2+N for one clock.
- R7: Hardware mode: a rising edge before timeout reloads the full stored count. The only strobe comes N clocks after the most recent trigger is loaded.
- R8: Hardware mode: accepting a count only stores it for later triggers and starts no count. Apart from its rising edge, the gate level has no effect: dropping the gate during a count does not move the strobe.
- R9: Exactly one strobe occurs per trigger. The counter does not reload after terminal count.
- R10: `load_ready` is high in every cycle after reset, so every cycle with `load_valid` high is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_hw | input | 1 | 0 = software trigger, 1 = hardware (gate edge) trigger |
| gate_in | input | 1 | Gate / trigger input, may be asynchronous |
| load_valid | input | 1 | Count transfer valid |
| load_ready | output | 1 | Count transfer ready, always high |
| load_count | input | CNT_W | Count value N |
| strobe_n | output | 1 | Active-low one-clock strobe |

## Verification
Random counts in both modes, with the gate held steady, pin down the basic load-to-strobe and edge-to-strobe latencies. These runs show an off-by-one in the counter apart from an error in the synchronizer depth. In the random hardware runs the gate drops at a random point during the count, which separates an edge-triggered design from one that treats the gate as a level. Directed cases cover a gate low pulse inside a software count (one clock of delay for each inhibited clock), a reload during counting, and a retrigger before timeout. A hardware-mode load with no edge must produce nothing, and a long gate-high hold must give a single strobe.

// File: rtl/strb_pkg.sv
package strb_pkg;
  typedef enum logic {
    MODE_SW = 1'b0,
    MODE_HW = 1'b1
  } strb_mode_e;
endpackage

// File: rtl/strb_sync.sv
// Multi-stage synchronizer with a registered rising-edge detector.
module strb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic level_o,
  output logic rise_o
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] sr;
  logic          prev;

  generate
    if (STAGES > 1) begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr <= '0;
        else        sr <= {sr[LAST-1:0], async_in};
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr <= '0;
        else        sr <= async_in;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= sr[LAST];
  end

  assign level_o = sr[LAST];
  assign rise_o  = sr[LAST] & ~prev;
endmodule

// File: rtl/strb_counter.sv
// Loadable down counter with a terminal (value one) flag.
module strb_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec_en,
  output logic [CNT_W-1:0] cnt_o,
  output logic             at_one_o
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (load_en) cnt <= load_val;
    else if (dec_en)  cnt <= cnt - 1'b1;
  end

  assign cnt_o    = cnt;
  assign at_one_o = (cnt == CNT_W'(1));
endmodule

// File: rtl/strb_ctrl.sv
// Trigger selection, arming and strobe generation.
module strb_ctrl
  import strb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  strb_mode_e mode,
  input  logic       mode_chg,
  input  logic       load_fire,
  input  logic       gate_lvl,
  input  logic       gate_rise,
  input  logic       at_one,
  output logic       cnt_load,
  output logic       dec_en,
  output logic       armed_o,
  output logic       strobe_n
);
  logic armed;
  logic trigger;
  logic run;
  logic terminal;

  always_comb begin
    trigger  = (mode == MODE_SW) ? load_fire : gate_rise;
    run      = (mode == MODE_SW) ? gate_lvl : 1'b1;
    terminal = armed & run & at_one;
    cnt_load = trigger & ~mode_chg;
    dec_en   = armed & run & ~at_one & ~trigger & ~mode_chg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      strobe_n <= 1'b1;
    end else if (mode_chg) begin
      armed    <= 1'b0;
      strobe_n <= 1'b1;
    end else if (trigger) begin
      armed    <= 1'b1;
      strobe_n <= 1'b1;
    end else if (terminal) begin
      armed    <= 1'b0;
      strobe_n <= 1'b0;
    end else begin
      strobe_n <= 1'b1;
    end
  end

  assign armed_o = armed;
endmodule

// File: rtl/strb_timer.sv
module strb_timer
  import strb_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_hw,
  input  logic             gate_in,
  input  logic             load_valid,
  output logic             load_ready,
  input  logic [CNT_W-1:0] load_count,
  output logic             strobe_n
);
  strb_mode_e       mode;
  strb_mode_e       mode_q;
  logic             mode_chg;
  logic             load_fire;
  logic             gate_lvl;
  logic             gate_rise;
  logic [CNT_W-1:0] period;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_val;
  logic             at_one;
  logic             cnt_load;
  logic             dec_en;
  logic             armed;

  assign mode       = strb_mode_e'(mode_hw);
  assign load_ready = 1'b1;
  assign load_fire  = load_valid & load_ready;
  assign mode_chg   = (mode != mode_q);
  assign cnt_val    = load_fire ? load_count : period;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_SW;
      period <= '0;
    end else begin
      mode_q <= mode;
      if (load_fire) period <= load_count;
    end
  end

  strb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(gate_in),
    .level_o(gate_lvl), .rise_o(gate_rise)
  );

  strb_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .mode(mode), .mode_chg(mode_chg),
    .load_fire(load_fire), .gate_lvl(gate_lvl), .gate_rise(gate_rise),
    .at_one(at_one), .cnt_load(cnt_load), .dec_en(dec_en),
    .armed_o(armed), .strobe_n(strobe_n)
  );

  strb_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load_en(cnt_load), .load_val(cnt_val),
    .dec_en(dec_en), .cnt_o(cnt), .at_one_o(at_one)
  );
endmodule

// File: rtl/strb_timer_chk.sv
module strb_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             strobe_n,
  input logic             mode_hw,
  input logic             mode_chg,
  input logic             load_fire,
  input logic [CNT_W-1:0] load_count,
  input logic             gate_lvl,
  input logic             gate_rise,
  input logic             armed,
  input logic [CNT_W-1:0] cnt
);
  p_mode_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> (strobe_n && !armed));

  p_one_wide_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_n |=> strobe_n);

  p_gate_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !mode_hw && !gate_lvl && !load_fire && !mode_chg)
    |=> ($stable(cnt) && strobe_n));

  p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_hw && load_fire && !mode_chg)
    |=> (armed && strobe_n && cnt == $past(load_count)));

  p_retrigger_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_hw && gate_rise && !mode_chg) |=> (armed && strobe_n));

  p_hw_load_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_hw && load_fire && !armed && !gate_rise) |=> !armed);

  p_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe_n) |-> !armed);
endmodule

bind strb_timer strb_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .strobe_n(strobe_n), .mode_hw(mode_hw),
  .mode_chg(mode_chg), .load_fire(load_fire), .load_count(load_count),
  .gate_lvl(gate_lvl), .gate_rise(gate_rise), .armed(armed), .cnt(cnt)
);

// File: tb/sim_strb_timer.sv
module sim_strb_timer;
  localparam int W    = 16;
  localparam int SYNC = 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         mode_hw = 1'b0;
  logic         gate_in = 1'b0;
  logic         load_valid = 1'b0;
  logic         load_ready;
  logic [W-1:0] load_count = '0;
  logic         strobe_n;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int nstr = 0;
  int last_low = -100;
  int wide_err = 0;

  always #2 clk = ~clk;  // 250 MHz

  strb_timer #(.CNT_W(W), .SYNC_STAGES(SYNC)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_hw(mode_hw), .gate_in(gate_in),
    .load_valid(load_valid), .load_ready(load_ready),
    .load_count(load_count), .strobe_n(strobe_n)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && !strobe_n) begin
      if (last_low == cyc - 1) wide_err++;
      nstr++;
      last_low = cyc;
    end
  end

  function automatic int exp_sw(int k, int n, int inhib);
    return k + n + inhib;
  endfunction

  function automatic int exp_hw(int c, int n);
    return c + 1 + SYNC + n;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic clear_mon;
    nstr = 0;
    last_low = -100;
  endtask

  task automatic do_load(input int n, output int k);
    load_valid = 1'b1;
    load_count = W'(n);
    k = cyc + 1;
    @(negedge clk);
    load_valid = 1'b0;
  endtask

  task automatic set_mode(input bit hw);
    mode_hw = hw;
    wait_cyc(3);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    summary();
  end

  initial begin
    int k, c, k2, n, d;
    void'($urandom(32'd1234));
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);
    chk(strobe_n === 1'b1, "R1 reset strobe_n", strobe_n, 1);
    chk(load_ready === 1'b1, "R10 ready", load_ready, 1);

    // Software mode, random counts, gate high
    gate_in = 1'b1;
    wait_cyc(4);
    for (int i = 0; i < 16; i++) begin
      n = 1 + ($urandom % 40);
      clear_mon();
      do_load(n, k);
      chk(load_ready === 1'b1, "R10 ready during load", load_ready, 1);
      wait_cyc(n + 6);
      chk(nstr == 1, "R9 sw strobe count", nstr, 1);
      chk(last_low == exp_sw(k, n, 0), "R3 sw latency", last_low, exp_sw(k, n, 0));
    end

    // R4 gate inhibit pulse of L clocks
    for (int i = 0; i < 3; i++) begin
      int L;
      L = 2 + ($urandom % 8);
      clear_mon();
      do_load(30, k);
      wait_cyc(4);
      gate_in = 1'b0;
      wait_cyc(L);
      gate_in = 1'b1;
      wait_cyc(40);
      chk(nstr == 1, "R4 inhibit strobe count", nstr, 1);
      chk(last_low == exp_sw(k, 30, L), "R4 inhibit latency", last_low, exp_sw(k, 30, L));
    end

    // R5 reload during counting
    clear_mon();
    do_load(40, k);
    wait_cyc(9);
    do_load(15, k2);
    wait_cyc(45);
    chk(nstr == 1, "R5 reload strobe count", nstr, 1);
    chk(last_low == exp_sw(k2, 15, 0), "R5 reload latency", last_low, exp_sw(k2, 15, 0));

    // R1 mode change aborts a running count
    clear_mon();
    do_load(20, k);
    wait_cyc(5);
    gate_in = 1'b0;
    set_mode(1'b1);
    wait_cyc(30);
    chk(nstr == 0, "R1 mode change idle", nstr, 0);

    // R8 hardware load alone starts nothing
    clear_mon();
    do_load(12, k);
    wait_cyc(30);
    chk(nstr == 0, "R8 hw load idle", nstr, 0);

    // Hardware mode, random counts, gate dropped at random point
    for (int i = 0; i < 10; i++) begin
      n = 4 + ($urandom % 36);
      do_load(n, k);
      wait_cyc(2);
      clear_mon();
      gate_in = 1'b1;
      c = cyc;
      d = 1 + ($urandom % (n + 4));
      wait_cyc(d);
      gate_in = 1'b0;
      wait_cyc(n + 8 - d);
      chk(nstr == 1, "R8 hw strobe count", nstr, 1);
      chk(last_low == exp_hw(c, n), "R6 hw latency", last_low, exp_hw(c, n));
      wait_cyc(3);
    end

    // R7 retrigger before timeout
    do_load(20, k);
    wait_cyc(2);
    clear_mon();
    gate_in = 1'b1;
    wait_cyc(3);
    gate_in = 1'b0;
    wait_cyc(8);
    gate_in = 1'b1;
    c = cyc;
    wait_cyc(30);
    chk(nstr == 1, "R7 retrigger strobe count", nstr, 1);
    chk(last_low == exp_hw(c, 20), "R7 retrigger latency", last_low, exp_hw(c, 20));

    // R9 long gate hold gives single strobe
    clear_mon();
    wait_cyc(80);
    chk(nstr == 0, "R9 no repeat after hold", nstr, 0);
    gate_in = 1'b0;
    wait_cyc(4);

    chk(wide_err == 0, "R2 strobe width", wide_err, 0);
    summary();
  end
endmodule